// File: doc/BRIEF.md
# Shift-and-Add Multiply Step Unit

This block carries out a single step of an iterative shift-and-add multiply. Each time the step enable is raised it takes a partial product operand, a multiplicand operand and the current negative and overflow flags. It then forms a new partial product and a fresh set of four condition flags. It also shifts its internal 32-bit multiplier register (Y) right by one place.

A full multiply is built from a series of steps. First, Y is loaded with the multiplier through a dedicated load port. Next comes a run of 32 steps, each fed with the previous result and flags. The run ends with one more step whose multiplicand is zero. After that final step the high word of the product sits on the result output and the low word sits in Y. The sequencing and the register file belong to the surrounding logic.

Top module: `mulstep_unit`

## Requirements
- R1: The multiplicand is `rs2_val` when `imm_sel` is 0, and `imm13` sign-extended to 32 bits when `imm_sel` is 1.
- R2: The shifted partial product is `rs1_val` shifted right by one bit, with `flag_n_in XOR flag_v_in` placed in bit 31.
- R3: When bit 0 of Y is 1 the addend is the multiplicand; when it is 0 the addend is zero.
- R4: `result` is the 32-bit sum of the shifted partial product and the addend; `flag_n` is bit 31 of that sum and `flag_z` is 1 exactly when the sum is zero.
- R5: `flag_v` is 1 when both addends have the same bit 31 and the sum's bit 31 differs from it; `flag_c` is the unsigned carry out of bit 31.
- R6: On a step, Y is shifted right by one bit and bit 0 of the unshifted `rs1_val` becomes Y bit 31.
- R7: Y keeps its value in any cycle in which neither `step_en` nor `y_load` is high.
- R8: With `step_en` low, `y_load` writes `y_load_val` into Y; when both are high the step wins and the load value is discarded.
- R9: Result and flags appear on the outputs in the cycle after `step_en`, and `result_valid` is high for exactly that one cycle.
- R10: `result` and the four flags keep their values while `step_en` is low.
- R11: After synchronous reset `result`, all flags, `y_out` and `result_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Perform one multiply step this cycle |
| rs1_val | input | 32 | Previous partial product |
| rs2_val | input | 32 | Register multiplicand |
| imm_sel | input | 1 | 1 selects the immediate multiplicand |
| imm13 | input | 13 | Signed immediate multiplicand |
| flag_n_in | input | 1 | Current negative flag |
| flag_v_in | input | 1 | Current overflow flag |
| y_load | input | 1 | Load Y from y_load_val |
| y_load_val | input | 32 | Value written into Y |
| result | output | 32 | Registered step sum |
| flag_n | output | 1 | Negative flag of the sum |
| flag_z | output | 1 | Zero flag of the sum |
| flag_v | output | 1 | Overflow flag of the add |
| flag_c | output | 1 | Carry flag of the add |
| y_out | output | 32 | Current Y register |
| result_valid | output | 1 | High one cycle after a step |

## Verification
The step is tried with a register multiplicand and with negative and positive immediates, which separates the two sources and shows whether sign extension is done. It is also tried with Y bit 0 clear and set, which shows whether the addend is selected from Y. The four combinations of incoming N and V show whether the inserted bit is their exclusive OR rather than either flag alone. Operand pairs chosen to give a zero sum, a signed overflow and an unsigned carry separate the four flag rules from one another. Complete 33-step sequences for several operand pairs are compared with the true product, which catches errors in the ordering of the Y shift.

// File: rtl/mulstep_pkg.sv
package mulstep_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } mulstep_flags_t;
endpackage

// File: rtl/mulstep_operand.sv
module mulstep_operand #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic [W-1:0]     rs1_val,
  input  logic [W-1:0]     rs2_val,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm13,
  input  logic             flag_n_in,
  input  logic             flag_v_in,
  input  logic             y_lsb,
  output logic [W-1:0]     shifted,
  output logic [W-1:0]     addend
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] mcand;

  always_comb begin
    mcand   = imm_sel ? {{EXT_W{imm13[IMM_W-1]}}, imm13} : rs2_val;
    shifted = {flag_n_in ^ flag_v_in, rs1_val[W-1:1]};
    addend  = y_lsb ? mcand : '0;
  end
endmodule

// File: rtl/mulstep_adder.sv
module mulstep_adder
  import mulstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum,
  output mulstep_flags_t flags
);
  logic [W:0] wide;

  always_comb begin
    wide    = {1'b0, a} + {1'b0, b};
    sum     = wide[W-1:0];
    flags.n = wide[W-1];
    flags.z = (wide[W-1:0] == '0);
    flags.v = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
    flags.c = wide[W];
  end
endmodule

// File: rtl/mulstep_yreg.sv
module mulstep_yreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         rs1_lsb,
  input  logic         y_load,
  input  logic [W-1:0] y_load_val,
  output logic [W-1:0] y
);
  always_ff @(posedge clk) begin
    if (rst)          y <= '0;
    else if (step_en) y <= {rs1_lsb, y[W-1:1]};
    else if (y_load)  y <= y_load_val;
  end

  p_y_shift_r6: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (y[W-2:0] == $past(y[W-1:1])) && (y[W-1] == $past(rs1_lsb)));
  p_y_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !y_load) |=> $stable(y));
  p_y_load_r8: assert property (@(posedge clk) disable iff (rst)
    (y_load && !step_en) |=> (y == $past(y_load_val)));
endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
  import mulstep_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [W-1:0]     rs1_val,
  input  logic [W-1:0]     rs2_val,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm13,
  input  logic             flag_n_in,
  input  logic             flag_v_in,
  input  logic             y_load,
  input  logic [W-1:0]     y_load_val,
  output logic [W-1:0]     result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic [W-1:0]     y_out,
  output logic             result_valid
);
  logic [W-1:0]   shifted;
  logic [W-1:0]   addend;
  logic [W-1:0]   sum;
  mulstep_flags_t nflags;
  mulstep_flags_t flags_q;

  mulstep_operand #(.W(W), .IMM_W(IMM_W)) operand_i (
    .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_sel(imm_sel), .imm13(imm13),
    .flag_n_in(flag_n_in), .flag_v_in(flag_v_in), .y_lsb(y_out[0]),
    .shifted(shifted), .addend(addend)
  );

  mulstep_adder #(.W(W)) adder_i (
    .a(shifted), .b(addend), .sum(sum), .flags(nflags)
  );

  mulstep_yreg #(.W(W)) yreg_i (
    .clk(clk), .rst(rst), .step_en(step_en), .rs1_lsb(rs1_val[0]),
    .y_load(y_load), .y_load_val(y_load_val), .y(y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      flags_q      <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= step_en;
      if (step_en) begin
        result  <= sum;
        flags_q <= nflags;
      end
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

  p_valid_r9: assert property (@(posedge clk) disable iff (rst)
    step_en |=> result_valid);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> !result_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(result) && $stable(flags_q)));
  p_nz_r4: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> ((flag_n == result[W-1]) && (flag_z == (result == '0))));
  p_zero_add_r3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !y_out[0]) |=> (!flag_v && !flag_c));
endmodule

// File: tb/mulstep_unit_tb_top.sv
module mulstep_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [31:0] rs1_val = '0;
  logic [31:0] rs2_val = '0;
  logic        imm_sel = 1'b0;
  logic [12:0] imm13 = '0;
  logic        flag_n_in = 1'b0;
  logic        flag_v_in = 1'b0;
  logic        y_load = 1'b0;
  logic [31:0] y_load_val = '0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [31:0] y_out;
  logic        result_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mulstep_unit dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imm_sel(imm_sel), .imm13(imm13), .flag_n_in(flag_n_in), .flag_v_in(flag_v_in),
    .y_load(y_load), .y_load_val(y_load_val), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .y_out(y_out),
    .result_valid(result_valid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] r1, input logic [31:0] r2, input logic isel,
                       input logic [12:0] imm, input logic n, input logic v,
                       input logic [31:0] y, output logic [31:0] s, output logic [3:0] f,
                       output logic [31:0] ny);
    logic [31:0] mc, sh, ad;
    logic [32:0] w;
    mc = isel ? 32'(signed'(imm)) : r2;
    sh = {n ^ v, r1[31:1]};
    ad = y[0] ? mc : 32'd0;
    w  = {1'b0, sh} + {1'b0, ad};
    s  = w[31:0];
    f  = {w[31], w[31:0] == 0, (sh[31] == ad[31]) && (w[31] != sh[31]), w[32]};
    ny = {r1[0], y[31:1]};
  endtask

  task automatic load_y(input logic [31:0] val);
    @(negedge clk);
    y_load = 1'b1; y_load_val = val;
    @(negedge clk);
    y_load = 1'b0;
  endtask

  task automatic do_step(input logic [31:0] r1, input logic [31:0] r2, input logic isel,
                         input logic [12:0] imm, input logic n, input logic v, string req);
    logic [31:0] s, ny;
    logic [3:0] f;
    model(r1, r2, isel, imm, n, v, y_out, s, f, ny);
    @(negedge clk);
    rs1_val = r1; rs2_val = r2; imm_sel = isel; imm13 = imm;
    flag_n_in = n; flag_v_in = v; step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check({req, " result"}, 64'(result), 64'(s));
    check({req, " flags"}, 64'({flag_n, flag_z, flag_v, flag_c}), 64'(f));
    check({req, " y"}, 64'(y_out), 64'(ny));
    check("R9 valid", 64'(result_valid), 64'd1);
  endtask

  task automatic t_reset;
    check("R11 result", 64'(result), 64'd0);
    check("R11 flags", 64'({flag_n, flag_z, flag_v, flag_c}), 64'd0);
    check("R11 y", 64'(y_out), 64'd0);
    check("R11 valid", 64'(result_valid), 64'd0);
  endtask

  task automatic t_operands;
    load_y(32'h0000_0001);
    do_step(32'h0000_1000, 32'h0000_0123, 1'b0, 13'h1FFF, 1'b0, 1'b0, "R1 rs2");
    load_y(32'h0000_0001);
    do_step(32'h0000_1000, 32'h0000_0123, 1'b1, 13'h1FF0, 1'b0, 1'b0, "R1 neg imm");
    load_y(32'h0000_0003);
    do_step(32'h0000_0000, 32'h0, 1'b1, 13'h0FFF, 1'b0, 1'b0, "R1 pos imm");
  endtask

  task automatic t_nv;
    for (int k = 0; k < 4; k++) begin
      load_y(32'h0);
      do_step(32'h0000_0F0F, 32'h5, 1'b0, 13'h0, k[0], k[1], "R2 nxorv");
    end
  endtask

  task automatic t_ysel;
    load_y(32'hFFFF_FFFE);
    do_step(32'h0000_0100, 32'h7777_0000, 1'b0, 13'h0, 1'b0, 1'b0, "R3 y0 clear");
    load_y(32'h0000_0001);
    do_step(32'h0000_0100, 32'h7777_0000, 1'b0, 13'h0, 1'b0, 1'b0, "R3 y0 set");
  endtask

  task automatic t_flags;
    load_y(32'h0);
    do_step(32'h0000_0001, 32'h0, 1'b0, 13'h0, 1'b0, 1'b0, "R4 zero");
    load_y(32'h1);
    do_step(32'h7FFF_FFFE, 32'h7FFF_FFFF, 1'b0, 13'h0, 1'b0, 1'b0, "R5 overflow");
    load_y(32'h1);
    do_step(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 13'h0, 1'b1, 1'b0, "R5 carry");
    load_y(32'h1);
    do_step(32'h0000_0002, 32'hFFFF_FFFF, 1'b0, 13'h0, 1'b0, 1'b0, "R5 wrap zero");
  endtask

  task automatic t_hold;
    logic [31:0] r;
    logic [3:0] f;
    logic [31:0] y;
    r = result; f = {flag_n, flag_z, flag_v, flag_c}; y = y_out;
    @(negedge clk);
    rs1_val = 32'hDEAD_BEEF; rs2_val = 32'h1234_5678; flag_n_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 result hold", 64'(result), 64'(r));
    check("R10 flags hold", 64'({flag_n, flag_z, flag_v, flag_c}), 64'(f));
    check("R7 y hold", 64'(y_out), 64'(y));
    check("R9 valid low", 64'(result_valid), 64'd0);
  endtask

  task automatic t_load_prio;
    load_y(32'hA5A5_0F0F);
    check("R8 load", 64'(y_out), 64'h0000_0000_A5A5_0F0F);
    @(negedge clk);
    rs1_val = 32'h1; rs2_val = 32'h0; imm_sel = 1'b0; flag_n_in = 1'b0; flag_v_in = 1'b0;
    y_load = 1'b1; y_load_val = 32'h1111_1111; step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0; y_load = 1'b0;
    check("R8 step wins", 64'(y_out), 64'h0000_0000_D2D2_8787);
  endtask

  task automatic t_multiply(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] prod;
    load_y(b);
    @(negedge clk);
    rs1_val = 32'h0; flag_n_in = 1'b0; flag_v_in = 1'b0;
    for (int k = 0; k < 33; k++) begin
      do_step(rs1_val, (k == 32) ? 32'h0 : a, 1'b0, 13'h0, flag_n_in, flag_v_in, "R6 sequence");
      rs1_val = result; flag_n_in = flag_n; flag_v_in = flag_v;
    end
    prod = 64'(a) * 64'(b);
    check("R6 product", {result, y_out}, prod);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_operands();
    t_nv();
    t_ysel();
    t_flags();
    t_hold();
    t_load_prio();
    t_multiply(32'd7, 32'd5);
    t_multiply(32'd12345, 32'd6789);
    t_multiply(32'h7FFF_FFFF, 32'h0001_0003);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule